// File: doc/BRIEF.md
# GPIO Expander Interrupt Controller

This block holds the register state of two 8-bit general-purpose I/O ports and turns pin activity into interrupt requests. Each pin has a data-in view, an output value, a direction bit and an open-drain select. It also has three trigger controls: rise enable, fall enable and a level polarity. A pin whose rise and fall enables are both zero is level-sensitive. Its polarity bit then picks whether high or low is the active state. Setting either enable, or both, makes the pin edge-sensitive on the chosen transitions.

Pin inputs are synchronized by two flops before detection. A detected event sets a sticky per-pin pending bit, which software clears by writing a one. Pending bits whose per-pin alert mask is set are combined into one summary bit. That bit is bit 15, the vendor-defined bit, of a 16-bit alert register, which has its own mask bit and its own write-one-to-clear. The active-low alert output is low while the summary bit and its mask bit are both set. Access is a byte-wide synchronous register bus: writes take effect at the clock edge, and reads are combinational from the address.

A parameter selects a reduced variant. It keeps only port 0, and on that port only pins 2, 3, 4, 6 and 7 (valid mask 0xDC). Every other bit reads as zero.

Top module: `gpx_irq_ctrl`

## Requirements
- R1: Port n has an 8-byte bank at 0xC0 + 8*n, with these fields at offsets +0 to +7: data-in (read-only), data-out, direction, open-drain select, rise enable, fall enable, level polarity and alert mask. Data-out, direction and open-drain drive `pin_out`, `pin_dir` and `pin_ods`, with port n on bits [8n+7:8n]. Direction 1 means output, and open-drain 1 means open-drain.
- R2: A change on `pin_in` that is set up before clock edge t reads back through data-in after edge t+1, and not after edge t alone.
- R3: With rise enable = 1, a 0-to-1 transition of the synchronized pin sets its pending bit. With fall enable = 1, a 1-to-0 transition sets it. With both enables set, either transition sets it. No other activity sets the bit in edge mode.
- R4: With both enables = 0, the pending bit is set while the synchronized pin equals the polarity bit (1 = active high, 0 = active low). If the pin is still active when the bit is cleared, the bit reads 0 for the cycle after the clearing write and reads 1 again on the cycle after that.
- R5: Pending bits for port n read at 0xD4 + n. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. A pending bit stays set until it is cleared. A clear wins over an event in the same cycle.
- R6: A pending pin whose alert mask bit is 0 never sets the summary bit.
- R7: The summary bit is bit 15 of the alert register: byte 0x11, bit 7. It is set on the cycle after any masked pin is pending, and it stays set until it is cleared by writing 1 to byte 0x11 bit 7. Such a clear has no effect while a masked pin is still pending. All other bits of the alert register (bytes 0x10 and 0x11) read 0.
- R8: The alert mask bit for bit 15 is byte 0x13, bit 7, and it resets to 0. `alert_n` is 0 exactly while the summary bit and that mask bit are both 1. It goes high on the cycle after the clearing write.
- R9: With REDUCED = 1, only port 0 bits 2, 3, 4, 6 and 7 (mask 0xDC) are stored or can become pending. All other port bits, and the whole of port 1, read 0 and drive 0.
- R10: A pin-mux control byte at 0xD0 is readable and writable, and drives `mux_ctl`.
- R11: During reset every register reads 0 and `alert_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, sampled at the clock edge |
| reg_addr | input | 8 | Byte address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| pin_in | input | 16 | Raw pin levels, port n on bits [8n+7:8n] |
| pin_out | output | 16 | Output values of the data-out registers |
| pin_dir | output | 16 | Direction bits, 1 = output |
| pin_ods | output | 16 | Open-drain select bits, 1 = open-drain |
| mux_ctl | output | 8 | Pin-mux control byte |
| alert_n | output | 1 | Active-low alert |

## Verification
The assertions check on every cycle that:
- a written clear removes pending bits on the next cycle;
- pending bits that are not cleared are never lost;
- invalid pins never become pending;
- the summary bit follows masked pending pins and holds until it is explicitly cleared.

Only the bench scenarios can show the rest. The trigger decoding is swept over every rise, fall and polarity combination against each start and end level. The bench also covers:
- the one-cycle gap of a level re-trigger;
- the two-edge synchronizer delay;
- the effect of the per-pin mask and the summary mask on `alert_n`;
- the reduced variant's zeroed bits.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam int PIN_W = 8;
    localparam logic [7:0] BANK_BASE = 8'hC0;
    localparam logic [7:0] MUX_ADDR  = 8'hD0;
    localparam logic [7:0] STAT_BASE = 8'hD4;
    localparam logic [7:0] SUM_LO    = 8'h10;
    localparam logic [7:0] SUM_HI    = 8'h11;
    localparam logic [7:0] SMSK_LO   = 8'h12;
    localparam logic [7:0] SMSK_HI   = 8'h13;
    localparam logic [7:0] RED_VALID = 8'hDC;

    typedef enum logic [2:0] {
        F_DIN, F_DOUT, F_DIR, F_ODS, F_RISE, F_FALL, F_POL, F_MASK
    } bank_field_e;

    typedef struct packed {
        logic [PIN_W-1:0] dout;
        logic [PIN_W-1:0] dir;
        logic [PIN_W-1:0] ods;
        logic [PIN_W-1:0] rise;
        logic [PIN_W-1:0] fall;
        logic [PIN_W-1:0] pol;
        logic [PIN_W-1:0] msk;
    } bank_cfg_t;

    function automatic logic [PIN_W-1:0] pin_valid(input int port, input bit reduced);
        if (!reduced) return '1;
        return (port == 0) ? RED_VALID : '0;
    endfunction
endpackage

// File: rtl/gpx_pin_sync.sv
module gpx_pin_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] now_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.s1   = raw_i;
        sync_d.s2   = sync_q.s1;
        sync_d.prev = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign now_o  = sync_q.s2;
    assign rise_o = sync_q.s2 & ~sync_q.prev;
    assign fall_o = ~sync_q.s2 & sync_q.prev;
endmodule

// File: rtl/gpx_pin_events.sv
module gpx_pin_events
    import gpx_pkg::*;
#(
    parameter logic [PIN_W-1:0] VALID = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] rise_en_i,
    input  logic [PIN_W-1:0] fall_en_i,
    input  logic [PIN_W-1:0] pol_i,
    input  logic [PIN_W-1:0] now_i,
    input  logic [PIN_W-1:0] rise_i,
    input  logic [PIN_W-1:0] fall_i,
    input  logic [PIN_W-1:0] clr_i,
    output logic [PIN_W-1:0] pend_o
);
    typedef struct packed {
        logic [PIN_W-1:0] pend;
    } evt_t;

    evt_t evt_d, evt_q;
    logic [PIN_W-1:0] edge_mode, hit;

    always_comb begin
        evt_d     = evt_q;
        edge_mode = rise_en_i | fall_en_i;
        hit       = (edge_mode & ((rise_en_i & rise_i) | (fall_en_i & fall_i)))
                  | (~edge_mode & ~(now_i ^ pol_i));
        evt_d.pend = (evt_q.pend | hit) & ~clr_i & VALID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= evt_d;
    end

    assign pend_o = evt_q.pend;

    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_i) |=> ((pend_o & $past(clr_i)) == '0));                 // R5
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_o & $past(pend_o & ~clr_i)) == $past(pend_o & ~clr_i))); // R5
    AST_PEND_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o & ~VALID) == '0);                                       // R9
endmodule

// File: rtl/gpx_irq_ctrl.sv
module gpx_irq_ctrl
    import gpx_pkg::*;
#(
    parameter int NPORT   = 2,
    parameter bit REDUCED = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [7:0]             reg_addr,
    input  logic [7:0]             reg_wdata,
    output logic [7:0]             reg_rdata,
    input  logic [NPORT*PIN_W-1:0] pin_in,
    output logic [NPORT*PIN_W-1:0] pin_out,
    output logic [NPORT*PIN_W-1:0] pin_dir,
    output logic [NPORT*PIN_W-1:0] pin_ods,
    output logic [7:0]             mux_ctl,
    output logic                   alert_n
);
    localparam int TOT_W = NPORT * PIN_W;

    typedef struct packed {
        bank_cfg_t [NPORT-1:0] cfg;
        logic [7:0]            mux;
        logic                  sum;
        logic                  smsk;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [TOT_W-1:0]             now_w, rise_w, fall_w;
    logic [NPORT-1:0][PIN_W-1:0]  pend, clr;
    logic                         any_pend, sum_clr;

    gpx_pin_sync #(.W(TOT_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_i(pin_in),
        .now_o(now_w), .rise_o(rise_w), .fall_o(fall_w)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        gpx_pin_events #(.VALID(pin_valid(p, REDUCED))) u_evt (
            .clk(clk), .rst_n(rst_n),
            .rise_en_i(ctl_q.cfg[p].rise), .fall_en_i(ctl_q.cfg[p].fall),
            .pol_i(ctl_q.cfg[p].pol),
            .now_i(now_w[p*PIN_W +: PIN_W]),
            .rise_i(rise_w[p*PIN_W +: PIN_W]),
            .fall_i(fall_w[p*PIN_W +: PIN_W]),
            .clr_i(clr[p]), .pend_o(pend[p])
        );
        assign pin_out[p*PIN_W +: PIN_W] = ctl_q.cfg[p].dout;
        assign pin_dir[p*PIN_W +: PIN_W] = ctl_q.cfg[p].dir;
        assign pin_ods[p*PIN_W +: PIN_W] = ctl_q.cfg[p].ods;
    end

    // Next-state: bank writes, status clears, summary bit and its mask.
    always_comb begin
        ctl_d    = ctl_q;
        any_pend = 1'b0;
        sum_clr  = reg_wr && (reg_addr == SUM_HI) && reg_wdata[7];
        for (int p = 0; p < NPORT; p++) begin
            clr[p] = (reg_wr && reg_addr == STAT_BASE + 8'(p)) ? reg_wdata : '0;
            any_pend = any_pend | (|(pend[p] & ctl_q.cfg[p].msk));
            if (reg_wr && reg_addr[7:3] == BANK_BASE[7:3] + 5'(p)) begin
                case (bank_field_e'(reg_addr[2:0]))
                    F_DOUT: ctl_d.cfg[p].dout = reg_wdata & pin_valid(p, REDUCED);
                    F_DIR:  ctl_d.cfg[p].dir  = reg_wdata & pin_valid(p, REDUCED);
                    F_ODS:  ctl_d.cfg[p].ods  = reg_wdata & pin_valid(p, REDUCED);
                    F_RISE: ctl_d.cfg[p].rise = reg_wdata & pin_valid(p, REDUCED);
                    F_FALL: ctl_d.cfg[p].fall = reg_wdata & pin_valid(p, REDUCED);
                    F_POL:  ctl_d.cfg[p].pol  = reg_wdata & pin_valid(p, REDUCED);
                    F_MASK: ctl_d.cfg[p].msk  = reg_wdata & pin_valid(p, REDUCED);
                    default: ;
                endcase
            end
        end
        if (reg_wr && reg_addr == MUX_ADDR) ctl_d.mux  = reg_wdata;
        if (reg_wr && reg_addr == SMSK_HI)  ctl_d.smsk = reg_wdata[7];
        ctl_d.sum = (ctl_q.sum & ~sum_clr) | any_pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // Read path
    always_comb begin
        reg_rdata = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (reg_addr[7:3] == BANK_BASE[7:3] + 5'(p)) begin
                case (bank_field_e'(reg_addr[2:0]))
                    F_DIN:  reg_rdata = now_w[p*PIN_W +: PIN_W] & pin_valid(p, REDUCED);
                    F_DOUT: reg_rdata = ctl_q.cfg[p].dout;
                    F_DIR:  reg_rdata = ctl_q.cfg[p].dir;
                    F_ODS:  reg_rdata = ctl_q.cfg[p].ods;
                    F_RISE: reg_rdata = ctl_q.cfg[p].rise;
                    F_FALL: reg_rdata = ctl_q.cfg[p].fall;
                    F_POL:  reg_rdata = ctl_q.cfg[p].pol;
                    F_MASK: reg_rdata = ctl_q.cfg[p].msk;
                    default: ;
                endcase
            end
            if (reg_addr == STAT_BASE + 8'(p)) reg_rdata = pend[p];
        end
        if (reg_addr == MUX_ADDR) reg_rdata = ctl_q.mux;
        if (reg_addr == SUM_HI)   reg_rdata = {ctl_q.sum, 7'd0};
        if (reg_addr == SMSK_HI)  reg_rdata = {ctl_q.smsk, 7'd0};
    end

    assign mux_ctl = ctl_q.mux;
    assign alert_n = ~(ctl_q.sum & ctl_q.smsk);

    AST_SUM_SET: assert property (@(posedge clk) disable iff (!rst_n)
        any_pend |=> ctl_q.sum);                                        // R7
    AST_SUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.sum && !(reg_wr && reg_addr == SUM_HI && reg_wdata[7])) |=> ctl_q.sum); // R7
    AST_ALERT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.smsk) |-> alert_n);                                      // R8
endmodule

// File: tb/gpx_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpx_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [15:0] pin_in = '0;
    logic [7:0]  rdata, red_rdata, mux_ctl, red_mux;
    logic [15:0] pin_out, pin_dir, pin_ods, red_out, red_dir, red_ods;
    logic        alert_n, red_alert_n;
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    gpx_irq_ctrl #(.NPORT(2), .REDUCED(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_dir(pin_dir), .pin_ods(pin_ods),
        .mux_ctl(mux_ctl), .alert_n(alert_n)
    );

    gpx_irq_ctrl #(.NPORT(2), .REDUCED(1'b1)) u_red (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(red_rdata), .pin_in(pin_in),
        .pin_out(red_out), .pin_dir(red_dir), .pin_ods(red_ods),
        .mux_ctl(red_mux), .alert_n(red_alert_n)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v, output logic [7:0] vr);
        reg_addr = a;
        #1;
        v = rdata; vr = red_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v, vr, exp;
        // R11: reset state
        repeat (3) @(posedge clk);
        #2;
        rd(8'hD4, v, vr); chk("R11 status in reset", {8'h0, v}, 16'h0);
        rd(8'hC2, v, vr); chk("R11 dir in reset", {8'h0, v}, 16'h0);
        chk("R11 alert_n in reset", {15'h0, alert_n}, 16'h1);
        chk("R11 pin_dir in reset", pin_dir, 16'h0);
        @(negedge clk) rst_n = 1'b1;
        idle(2);

        // R3 / R4: sweep of every trigger setting against start/end levels
        for (int m = 0; m < 8; m++) begin
            for (int a = 0; a < 2; a++) begin
                for (int b = 0; b < 2; b++) begin
                    logic r, f, pl;
                    r = m[0]; f = m[1]; pl = m[2];
                    pin_in[7:0] = {8{a[0]}};
                    wr(8'hC4, {8{r}});
                    wr(8'hC5, {8{f}});
                    wr(8'hC6, {8{pl}});
                    idle(6);
                    wr(8'hD4, 8'hFF);
                    idle(2);
                    pin_in[7:0] = {8{b[0]}};
                    idle(6);
                    rd(8'hD4, v, vr);
                    if (r | f)
                        exp = ((a == 0 && b == 1 && r) || (a == 1 && b == 0 && f)) ? 8'hFF : 8'h00;
                    else
                        exp = ((a[0] == pl) || (b[0] == pl)) ? 8'hFF : 8'h00;
                    chk((r | f) ? "R3 edge trigger" : "R4 level trigger", {8'h0, v}, {8'h0, exp});
                end
            end
        end

        // R5: partial write-one-to-clear, zero write ignored
        wr(8'hC4, 8'hFF); wr(8'hC5, 8'h00);
        pin_in[7:0] = 8'h00; idle(6);
        wr(8'hD4, 8'hFF);
        pin_in[7:0] = 8'hFF; idle(6);
        wr(8'hD4, 8'h00);
        rd(8'hD4, v, vr); chk("R5 zero write no effect", {8'h0, v}, 16'h00FF);
        wr(8'hD4, 8'h0F);
        rd(8'hD4, v, vr); chk("R5 partial clear", {8'h0, v}, 16'h00F0);

        // R4: level re-trigger after one-cycle gap
        wr(8'hC4, 8'h00); wr(8'hC6, 8'hFF);
        idle(2);
        wr(8'hD4, 8'hFF);
        rd(8'hD4, v, vr); chk("R4 cleared cycle", {8'h0, v}, 16'h0000);
        @(posedge clk); #2;
        rd(8'hD4, v, vr); chk("R4 re-set next cycle", {8'h0, v}, 16'h00FF);

        // R6 / R7 / R8: masks and summary bit
        wr(8'h13, 8'h80);
        idle(2);
        rd(8'h11, v, vr); chk("R6 unmasked pin ignored", {8'h0, v}, 16'h0);
        chk("R6 alert_n high", {15'h0, alert_n}, 16'h1);
        wr(8'hC7, 8'h08);
        idle(1);
        rd(8'h11, v, vr); chk("R7 summary set", {8'h0, v}, 16'h0080);
        chk("R8 alert_n low", {15'h0, alert_n}, 16'h0);
        wr(8'h11, 8'h80);
        rd(8'h11, v, vr); chk("R7 clear while pending ignored", {8'h0, v}, 16'h0080);
        wr(8'hC4, 8'hFF);
        wr(8'hD4, 8'hFF);
        idle(1);
        rd(8'hD4, v, vr); chk("R5 edge status cleared", {8'h0, v}, 16'h0);
        wr(8'h11, 8'h80);
        rd(8'h11, v, vr); chk("R7 summary cleared", {8'h0, v}, 16'h0);
        chk("R8 alert_n released after clear", {15'h0, alert_n}, 16'h1);
        rd(8'h10, v, vr); chk("R7 low byte zero", {8'h0, v}, 16'h0);
        pin_in[7:0] = 8'h00; idle(6);
        pin_in[7:0] = 8'hFF; idle(6);
        chk("R8 alert_n low again", {15'h0, alert_n}, 16'h0);
        wr(8'h13, 8'h00);
        chk("R8 mask off releases alert", {15'h0, alert_n}, 16'h1);
        rd(8'h11, v, vr); chk("R8 summary kept with mask off", {8'h0, v}, 16'h0080);

        // R1: port 1 bank and pin outputs
        wr(8'hC9, 8'hA5); wr(8'hCA, 8'h3C); wr(8'hCB, 8'hC3);
        chk("R1 pin_out port1", {8'h0, pin_out[15:8]}, 16'h00A5);
        chk("R1 pin_dir port1", {8'h0, pin_dir[15:8]}, 16'h003C);
        chk("R1 pin_ods port1", {8'h0, pin_ods[15:8]}, 16'h00C3);
        rd(8'hCA, v, vr); chk("R1 dir readback", {8'h0, v}, 16'h003C);
        wr(8'hC2, 8'h81);
        chk("R1 pin_dir port0", {8'h0, pin_dir[7:0]}, 16'h0081);

        // R2: two-edge synchronizer delay on data-in
        @(negedge clk) pin_in[15:8] = 8'h96;
        @(posedge clk); #1;
        rd(8'hC8, v, vr); chk("R2 not yet visible", {8'h0, v}, 16'h0000);
        @(posedge clk); #1;
        rd(8'hC8, v, vr); chk("R2 visible after second edge", {8'h0, v}, 16'h0096);

        // R10: mux control
        wr(8'hD0, 8'h5A);
        rd(8'hD0, v, vr); chk("R10 mux readback", {8'h0, v}, 16'h005A);
        chk("R10 mux_ctl", {8'h0, mux_ctl}, 16'h005A);

        // R9: reduced variant
        wr(8'hC4, 8'hFF); wr(8'hC5, 8'h00);
        pin_in = 16'h0000; idle(6);
        wr(8'hD4, 8'hFF); wr(8'hD5, 8'hFF);
        pin_in = 16'hFFFF; idle(6);
        rd(8'hD4, v, vr); chk("R9 reduced port0 status", {8'h0, vr}, 16'h00DC);
        rd(8'hD5, v, vr); chk("R9 reduced port1 status", {8'h0, vr}, 16'h0000);
        wr(8'hC9, 8'hFF);
        rd(8'hC9, v, vr); chk("R9 reduced port1 out", {8'h0, vr}, 16'h0000);
        wr(8'hC1, 8'hFF);
        chk("R9 reduced pin_out", red_out, 16'h00DC);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule